// File: doc/BRIEF.md
# Operation Issue and Handshake Manager

This block is the control shell around a functional unit that runs one operation at a time. A one-cycle issue pulse loads an opcode and its operand-control fields into the shell. The shell then asks for each source operand it needs. Each source has its own request line and a one-cycle grant that carries the data.

Once every needed source has arrived, the shell hands the operands and the opcode to an execution core over a valid/ready handshake. It takes the result back over a second valid/ready handshake. It then raises a write request and holds the result until a one-cycle write grant accepts it. The busy flag covers the whole operation from the cycle after issue until the write grant, so no operation can be lost.

Three things can stand in for a source read. Source 0 can be forced to zero. Source 1 can be replaced by an immediate value. Either source can be suppressed by its bit in an active-low read-mask vector. A suppressed or replaced source raises no read request.

Top module: `opunit_ctrl`

## Requirements
- R1: After reset, and for as long as no issue pulse arrives, `busy`, both `rd_req` bits, `wr_req` and `core_in_valid` are low.
- R2: An issue pulse seen while idle makes `busy` go high in the next cycle. `busy` never rises without a preceding issue. The environment never drives issue while busy is high.
- R3: `op_code`, `op_zero_a`, `op_imm_en` and `op_imm` are captured in the issue cycle. Changing them afterwards has no effect on the result of the operation in flight. `rd_mask_n` is also captured at issue.
- R4: Each needed read request (`rd_req[0]` for source 0, `rd_req[1]` for source 1) rises in the cycle after issue. It stays high for any number of cycles until its grant is seen.
- R5: A grant may arrive in the same cycle its request first appears. Source data is taken only in the grant cycle. The request is low in the cycle after the grant.
- R6: With `op_zero_a` set, `rd_req[0]` never rises and source 0 is 0. With `op_imm_en` set, `rd_req[1]` never rises and source 1 is `op_imm`. The immediate takes priority over mask bit 1.
- R7: A set `rd_mask_n[i]` bit (bit 0 for source 0, bit 1 for source 1) suppresses `rd_req[i]` and supplies 0 as that source.
- R8: `wr_req` rises once the core returns a result, and `wr_data` holds that result while `wr_req` is high. `busy` stays high until the cycle after the write grant, then falls together with `wr_req`. With prompt grants, an operation completes within 50 cycles of issue.
- R9: `core_in_valid` is raised only after every needed read has completed. A core that answers in the same cycle it accepts (zero latency) still takes the operation through the full read, write and busy sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | One-cycle operation issue pulse |
| op_code | input | OPW | Opcode passed to the core |
| op_zero_a | input | 1 | Force source 0 to zero |
| op_imm_en | input | 1 | Replace source 1 with the immediate |
| op_imm | input | W | Immediate value |
| rd_mask_n | input | 2 | Active-low read mask, one bit per source |
| busy | output | 1 | Operation in flight |
| rd_req | output | 2 | Read requests, one per source |
| rd_gnt | input | 2 | Read grants, one per source |
| src0 | input | W | Source 0 data, valid with rd_gnt[0] |
| src1 | input | W | Source 1 data, valid with rd_gnt[1] |
| core_in_valid | output | 1 | Operands valid toward the core |
| core_in_ready | input | 1 | Core accepts operands |
| core_op | output | OPW | Latched opcode toward the core |
| core_a | output | W | Source 0 operand toward the core |
| core_b | output | W | Source 1 operand toward the core |
| core_out_valid | input | 1 | Core result valid |
| core_out_ready | output | 1 | Shell accepts the result |
| core_res | input | W | Core result |
| wr_req | output | 1 | Write request for the result |
| wr_gnt | input | 1 | Write grant |
| wr_data | output | W | Result, valid while wr_req is high |

## Verification
The operations vary the read-grant delay per source, including a zero-delay grant in the request cycle and grants given in a different order on each side. A correctly ordered result shows that each source was taken from its own grant cycle and not from the junk driven afterwards. The opcode and the immediate fields are scrambled right after issue, so a wrong result points to a missing capture.

The other cases separate the bypass paths from real reads:
- zero-source operations;
- immediate operations;
- operations with each mask bit set;
- operations with both mask bits set.

The core latency ranges from zero to three cycles, and the write grant is held back for a variable time. This exposes a busy flag that falls early or a core handshake that starts before the reads finish.

// File: rtl/opunit_ctrl.sv
module opunit_ctrl #(
  parameter int W   = 16,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           issue,
  input  logic [OPW-1:0] op_code,
  input  logic           op_zero_a,
  input  logic           op_imm_en,
  input  logic [W-1:0]   op_imm,
  input  logic [1:0]     rd_mask_n,
  output logic           busy,
  output logic [1:0]     rd_req,
  input  logic [1:0]     rd_gnt,
  input  logic [W-1:0]   src0,
  input  logic [W-1:0]   src1,
  output logic           core_in_valid,
  input  logic           core_in_ready,
  output logic [OPW-1:0] core_op,
  output logic [W-1:0]   core_a,
  output logic [W-1:0]   core_b,
  input  logic           core_out_valid,
  output logic           core_out_ready,
  input  logic [W-1:0]   core_res,
  output logic           wr_req,
  input  logic           wr_gnt,
  output logic [W-1:0]   wr_data
);

  typedef enum logic [2:0] {S_IDLE, S_READ, S_EXEC, S_WAIT, S_WRITE} st_t;

  st_t            st;
  logic [OPW-1:0] op_q;
  logic [W-1:0]   a_q, b_q, res_q;
  logic [1:0]     need_rd;

  assign need_rd = {~(op_imm_en | rd_mask_n[1]), ~(op_zero_a | rd_mask_n[0])};

  assign busy           = (st != S_IDLE);
  assign wr_req         = (st == S_WRITE);
  assign wr_data        = res_q;
  assign core_in_valid  = (st == S_EXEC);
  assign core_out_ready = (st == S_EXEC) || (st == S_WAIT);
  assign core_op        = op_q;
  assign core_a         = a_q;
  assign core_b         = b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rd_req <= '0;
      op_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      res_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (issue) begin
          st     <= S_READ;
          op_q   <= op_code;
          rd_req <= need_rd;
          a_q    <= '0;
          b_q    <= op_imm_en ? op_imm : '0;
        end
        S_READ: begin
          if (rd_req[0] && rd_gnt[0]) begin
            a_q       <= src0;
            rd_req[0] <= 1'b0;
          end
          if (rd_req[1] && rd_gnt[1]) begin
            b_q       <= src1;
            rd_req[1] <= 1'b0;
          end
          if ((rd_req & ~rd_gnt) == 2'b00) st <= S_EXEC;
        end
        S_EXEC: if (core_in_ready) begin
          if (core_out_valid) begin
            res_q <= core_res;
            st    <= S_WRITE;
          end else begin
            st <= S_WAIT;
          end
        end
        S_WAIT: if (core_out_valid) begin
          res_q <= core_res;
          st    <= S_WRITE;
        end
        S_WRITE: if (wr_gnt) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/opunit_ctrl_chk.sv
module opunit_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       issue,
  input logic       busy,
  input logic [1:0] rd_req,
  input logic [1:0] rd_gnt,
  input logic       core_in_valid,
  input logic       wr_req,
  input logic       wr_gnt
);

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_req == 2'b00) && !wr_req && !core_in_valid);

  p_busy_from_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue));

  p_no_issue_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !issue);

  p_rd0_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req[0]) |-> $past(issue));

  p_rd1_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_req[1]) |-> $past(issue));

  p_rd0_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[0] && !rd_gnt[0] |=> rd_req[0]);

  p_rd1_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[1] && !rd_gnt[1] |=> rd_req[1]);

  p_rd0_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[0] && rd_gnt[0] |=> !rd_req[0]);

  p_rd1_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req[1] && rd_gnt[1] |=> !rd_req[1]);

  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(wr_req && wr_gnt) |=> busy);

  p_busy_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && wr_gnt |=> !busy && !wr_req);

  p_core_after_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    core_in_valid |-> (rd_req == 2'b00));

endmodule

bind opunit_ctrl opunit_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .issue(issue), .busy(busy), .rd_req(rd_req),
  .rd_gnt(rd_gnt), .core_in_valid(core_in_valid), .wr_req(wr_req), .wr_gnt(wr_gnt)
);

// File: tb/opunit_ctrl_tb.sv
module opunit_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int OPW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue = 0, op_zero_a = 0, op_imm_en = 0;
  logic [OPW-1:0] op_code = '0;
  logic [W-1:0] op_imm = '0, src0 = '0, src1 = '0;
  logic [1:0] rd_mask_n = '0, rd_req, rd_gnt = '0;
  logic busy, core_in_valid, core_in_ready, core_out_valid, core_out_ready;
  logic [OPW-1:0] core_op;
  logic [W-1:0] core_a, core_b, core_res, wr_data;
  logic wr_req, wr_gnt = 0;

  int errors = 0, checks = 0;
  int lat = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  opunit_ctrl #(.W(W), .OPW(OPW)) u_dut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .op_code(op_code),
    .op_zero_a(op_zero_a), .op_imm_en(op_imm_en), .op_imm(op_imm),
    .rd_mask_n(rd_mask_n), .busy(busy), .rd_req(rd_req), .rd_gnt(rd_gnt),
    .src0(src0), .src1(src1), .core_in_valid(core_in_valid),
    .core_in_ready(core_in_ready), .core_op(core_op), .core_a(core_a),
    .core_b(core_b), .core_out_valid(core_out_valid),
    .core_out_ready(core_out_ready), .core_res(core_res), .wr_req(wr_req),
    .wr_gnt(wr_gnt), .wr_data(wr_data)
  );

  function automatic logic [W-1:0] alu(input logic [OPW-1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op[1:0])
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a & b;
      default: return a ^ b;
    endcase
  endfunction

  logic pend = 0;
  int cnt = 0;
  logic [OPW-1:0] pop;
  logic [W-1:0] pa, pb;
  logic early_core = 0;

  assign core_in_ready  = !pend;
  assign core_out_valid = (lat == 0) ? core_in_valid : (pend && cnt == 0);
  assign core_res       = (lat == 0) ? alu(core_op, core_a, core_b) : alu(pop, pa, pb);

  always @(posedge clk) begin
    if (core_in_valid && rd_req != 2'b00) early_core <= 1'b1;
    if (core_in_valid && core_in_ready && lat != 0) begin
      pend <= 1'b1; cnt <= lat - 1; pop <= core_op; pa <= core_a; pb <= core_b;
    end else if (pend) begin
      if (cnt != 0) cnt <= cnt - 1;
      else if (core_out_ready) pend <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd_agent(input int i, input bit need, input int dly, input logic [W-1:0] data);
    if (need) begin
      @(negedge clk);
      chk(rd_req[i] === 1'b1, "R4 request rises after issue", rd_req[i], 1);
      for (int k = 0; k < dly; k++) begin
        @(negedge clk);
        chk(rd_req[i] === 1'b1, "R4 request held", rd_req[i], 1);
      end
      rd_gnt[i] = 1'b1;
      if (i == 0) src0 = data; else src1 = data;
      @(negedge clk);
      rd_gnt[i] = 1'b0;
      if (i == 0) src0 = 16'hDEAD; else src1 = 16'hBEEF;
      chk(rd_req[i] === 1'b0, "R5 request drops after grant", rd_req[i], 0);
    end else begin
      bit seen = 0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (rd_req[i] !== 1'b0) seen = 1;
        if (!busy) break;
      end
      chk(!seen, "R6/R7 no request for bypassed source", seen, 0);
    end
  endtask

  task automatic wr_agent(input int dly, input logic [W-1:0] exp);
    int cyc = 0;
    while (wr_req !== 1'b1 && cyc < 60) begin
      @(negedge clk); cyc++;
    end
    for (int k = 0; k < dly; k++) begin
      chk(busy === 1'b1, "R8 busy held before write grant", busy, 1);
      @(negedge clk); cyc++;
    end
    chk(wr_data === exp, "R8 result data", wr_data, exp);
    wr_gnt = 1'b1;
    @(negedge clk); cyc++;
    wr_gnt = 1'b0;
    chk(busy === 1'b0 && wr_req === 1'b0, "R8 busy falls after write grant", {busy, wr_req}, 0);
    chk(cyc <= 50, "R8 completion within 50 cycles", cyc, 50);
  endtask

  task automatic run_op(input string name, input logic [OPW-1:0] op, input logic [W-1:0] a,
                        input logic [W-1:0] b, input bit za, input bit ie, input logic [W-1:0] imm,
                        input logic [1:0] mask, input int d0, input int d1, input int dw, input int l);
    logic [W-1:0] ea, eb;
    bit n0, n1;
    n0 = !(za || mask[0]);
    n1 = !(ie || mask[1]);
    ea = n0 ? a : '0;
    eb = ie ? imm : (mask[1] ? '0 : b);
    lat = l;
    early_core = 0;
    @(negedge clk);
    chk(busy === 1'b0, "R1 idle before issue", busy, 0);
    issue = 1; op_code = op; op_zero_a = za; op_imm_en = ie; op_imm = imm; rd_mask_n = mask;
    fork
      begin
        @(negedge clk);
        chk(busy === 1'b1, "R2 busy one cycle after issue", busy, 1);
        issue = 0; op_code = ~op; op_zero_a = ~za; op_imm_en = ~ie; op_imm = ~imm;
      end
      rd_agent(0, n0, d0, a);
      rd_agent(1, n1, d1, b);
      wr_agent(dw, alu(op, ea, eb));
    join
    chk(!early_core, "R9 core started only after reads", early_core, 0);
    $display("done %s", name);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy === 0 && rd_req === 0 && wr_req === 0 && core_in_valid === 0, "R1 reset state",
        {busy, rd_req, wr_req, core_in_valid}, 0);
    rst_n = 1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(busy === 0 && rd_req === 0, "R1 stays idle without issue", {busy, rd_req}, 0);
    end
    run_op("add zero-delay",  4'd0, 16'd1234, 16'd4321, 0, 0, 16'd0,    2'b00, 0, 0, 0, 2);
    run_op("sub R3 R9 lat0",  4'd1, 16'd900,  16'd33,   0, 0, 16'd0,    2'b00, 3, 1, 2, 0);
    run_op("xor R6 zero_a",   4'd3, 16'hF0F0, 16'h0FF0, 1, 0, 16'd0,    2'b00, 0, 2, 1, 1);
    run_op("and R6 imm",      4'd2, 16'hFFFF, 16'h1111, 0, 1, 16'h3C3C, 2'b10, 1, 0, 0, 1);
    run_op("add R7 mask0",    4'd0, 16'd77,   16'd500,  0, 0, 16'd0,    2'b01, 0, 1, 0, 0);
    run_op("sub R7 mask1",    4'd1, 16'd500,  16'd77,   0, 0, 16'd0,    2'b10, 2, 0, 3, 3);
    run_op("xor R7 mask both",4'd3, 16'd5,    16'd9,    0, 0, 16'd0,    2'b11, 0, 0, 1, 0);
    run_op("add late grants", 4'd0, 16'hFFFF, 16'd2,    0, 0, 16'd0,    2'b00, 2, 0, 0, 3);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule